// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block turns one burst request into the stream of column addresses that an SDRAM read or write burst visits, one address per clock. A request is given by a start strobe, a starting column, a three-bit burst length code and a burst type bit. For fixed lengths of 2, 4 or 8, the column bits above the length stay fixed. Only the low bits move, either by counting with wrap-around (sequential) or by XOR with a beat index (interleaved). A full-page burst walks through every column of the row, wraps at the top, and runs until it is terminated.

A memory controller pulses the start strobe in the cycle it issues the read or write command. It then uses the per-beat column, the beat-valid flag and the last-beat flag to step its data path. A terminate input ends any burst early. A new start strobe replaces a running burst. An illegal length or type combination is refused with a one-cycle error pulse.

Top module: `burst_col_gen`

## Requirements
- R1: Length code (lenCode) selects the beat count: 0 gives 1 beat, 1 gives 2, 2 gives 4, 3 gives 8, and 7 gives a full page.
- R2: With burstType 0 (sequential), beat k carries the starting column's upper bits unchanged, and its low log2(L) bits equal (start low bits + k) mod L. For example, low bits 5 with L=8 give 5,6,7,0,1,2,3,4.
- R3: With burstType 1 (interleaved), beat k carries the starting column's upper bits unchanged, and its low log2(L) bits equal the start low bits XOR k. For example, low bits 5 with L=8 give 5,4,7,6,1,0,3,2.
- R4: Code 7 with sequential type steps through all 512 columns, wrapping from 511 to 0. It keeps producing beats until terminated.
- R5: With code 0, exactly one beat carries the starting column, whatever burstType is.
- R6: When termIn is high in a cycle that shows a beat (and startIn is low), that beat is the last one. beatValid is low in the next cycle.
- R7: Codes 4, 5 and 6, and code 7 with burstType 1, produce no beats. errFlag is high for exactly the one cycle after the start strobe.
- R8: A start strobe during a running burst abandons it. The next cycle shows beat 0 of the new request.
- R9: lastBeat is high exactly with the final beat of a fixed-length burst. It is never high during a full-page burst.
- R10: Beat 0 appears in the cycle after the start strobe is sampled, and consecutive beats follow on consecutive cycles. After reset, beatValid, lastBeat and errFlag are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| startIn | input | 1 | Start strobe for a new burst |
| startCol | input | 9 | Starting column |
| lenCode | input | 3 | Burst length code |
| burstType | input | 1 | 0 sequential, 1 interleaved |
| termIn | input | 1 | Terminate running burst |
| colOut | output | 9 | Column of the current beat |
| beatValid | output | 1 | A beat is presented this cycle |
| lastBeat | output | 1 | Current beat is the final one of a fixed-length burst |
| errFlag | output | 1 | One-cycle pulse after an illegal request |

## Verification
All results are registered once. Beat 0 and the error pulse are due one cycle after the start strobe. Each later beat is due one cycle after the previous one. The end of a burst after a terminate or a final beat shows one cycle after that beat. The bench drives inputs on the falling edge and samples on the next falling edge, so each sample sees exactly one rising edge's update. Every beat is compared against the column computed from the requirement formulas. The cycles just after the end of each burst are also checked.

// File: rtl/bcg_pkg.sv
package bcg_pkg;
  localparam int COL_W = 9;
  localparam int CODE_W = 3;
  localparam logic [CODE_W-1:0] CODE_FULL = 3'd7;
  localparam logic [CODE_W-1:0] CODE_MAXFIX = 3'd3;

  typedef struct packed {
    logic load;
    logic step;
  } bcgStrobes_t;

  function automatic logic [COL_W-1:0] lenMask(input logic [CODE_W-1:0] code);
    logic [COL_W-1:0] m;
    if (code == CODE_FULL) m = '1;
    else if (code <= CODE_MAXFIX) m = COL_W'((1 << code) - 1);
    else m = '0;
    return m;
  endfunction
endpackage

// File: rtl/bcg_ctrl.sv
module bcg_ctrl
  import bcg_pkg::*;
#(
  parameter int CW = CODE_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          startIn,
  input  logic [CW-1:0] lenCode,
  input  logic          burstType,
  input  logic          termIn,
  input  logic          atEnd,
  output bcgStrobes_t   strobes,
  output logic          active,
  output logic          lastNow,
  output logic          errPulse
);
  logic fullPg;
  logic legal;

  assign legal = (lenCode <= CODE_MAXFIX) || (lenCode == CODE_FULL && !burstType);
  assign lastNow = active && !fullPg && atEnd;
  assign strobes.load = startIn && legal;
  assign strobes.step = active && !startIn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active   <= 1'b0;
      fullPg   <= 1'b0;
      errPulse <= 1'b0;
    end else begin
      errPulse <= startIn && !legal;
      if (startIn) begin
        active <= legal;
        fullPg <= (lenCode == CODE_FULL);
      end else if (active && (termIn || lastNow)) begin
        active <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/bcg_addr.sv
module bcg_addr
  import bcg_pkg::*;
#(
  parameter int AW = COL_W,
  parameter int CW = CODE_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  bcgStrobes_t   strobes,
  input  logic [AW-1:0] startCol,
  input  logic [CW-1:0] lenCode,
  input  logic          burstType,
  output logic [AW-1:0] colOut,
  output logic          atEnd
);
  logic [AW-1:0] baseCol;
  logic [AW-1:0] mask;
  logic [AW-1:0] beatCnt;
  logic          interl;
  logic [AW-1:0] lowBits;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseCol <= '0;
      mask    <= '0;
      beatCnt <= '0;
      interl  <= 1'b0;
    end else if (strobes.load) begin
      baseCol <= startCol;
      mask    <= AW'(lenMask(lenCode));
      beatCnt <= '0;
      interl  <= burstType;
    end else if (strobes.step) begin
      beatCnt <= beatCnt + 1'b1;
    end
  end

  always_comb begin
    if (interl) lowBits = baseCol ^ beatCnt;
    else        lowBits = baseCol + beatCnt;
    colOut = (baseCol & ~mask) | (lowBits & mask);
  end

  assign atEnd = (beatCnt == mask);
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
  import bcg_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             startIn,
  input  logic [COL_W-1:0] startCol,
  input  logic [CODE_W-1:0] lenCode,
  input  logic             burstType,
  input  logic             termIn,
  output logic [COL_W-1:0] colOut,
  output logic             beatValid,
  output logic             lastBeat,
  output logic             errFlag
);
  bcgStrobes_t strobes;
  logic atEnd;

  bcg_ctrl #(.CW(CODE_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .startIn(startIn), .lenCode(lenCode),
    .burstType(burstType), .termIn(termIn), .atEnd(atEnd),
    .strobes(strobes), .active(beatValid), .lastNow(lastBeat),
    .errPulse(errFlag)
  );

  bcg_addr #(.AW(COL_W), .CW(CODE_W)) u_addr (
    .clk(clk), .rstN(rstN), .strobes(strobes), .startCol(startCol),
    .lenCode(lenCode), .burstType(burstType), .colOut(colOut), .atEnd(atEnd)
  );
endmodule

// File: rtl/bcg_checker.sv
module bcg_checker
  import bcg_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             startIn,
  input logic [COL_W-1:0] startCol,
  input logic [CODE_W-1:0] lenCode,
  input logic             burstType,
  input logic             termIn,
  input logic [COL_W-1:0] colOut,
  input logic             beatValid,
  input logic             lastBeat,
  input logic             errFlag
);
  logic reqOk;
  assign reqOk = (lenCode <= 3'd3) || (lenCode == 3'd7 && !burstType);

  AST_ERR_NO_BEAT: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |-> !beatValid); // R7
  AST_ERR_AFTER_BAD: assert property (@(posedge clk) disable iff (!rstN)
    (startIn && !reqOk) |=> errFlag); // R7
  AST_TERM_STOPS: assert property (@(posedge clk) disable iff (!rstN)
    (beatValid && termIn && !startIn) |=> !beatValid); // R6
  AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rstN)
    (lastBeat && !startIn) |=> !beatValid); // R9
  AST_LAST_IN_BEAT: assert property (@(posedge clk) disable iff (!rstN)
    lastBeat |-> beatValid); // R9
  AST_FIRST_BEAT: assert property (@(posedge clk) disable iff (!rstN)
    (startIn && reqOk) |=> (beatValid && colOut == $past(startCol))); // R10
endmodule

bind burst_col_gen bcg_checker u_chk (.*);

// File: tb/tb_burst_col_gen.sv
module tb_burst_col_gen;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startIn = 1'b0;
  logic [8:0] startCol = '0;
  logic [2:0] lenCode = '0;
  logic burstType = 1'b0;
  logic termIn = 1'b0;
  logic [8:0] colOut;
  logic beatValid, lastBeat, errFlag;
  int nChecks = 0;
  int nErrors = 0;

  always #2.5 clk = ~clk;

  burst_col_gen dut (.*);

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int expCol(int c, int len, int typ, int k);
    int low;
    if (typ == 1) low = (c % len) ^ k;
    else low = ((c % len) + k) % len;
    return (c / len) * len + low;
  endfunction

  task automatic issue(int c, int code, int typ);
    startIn = 1'b1; startCol = 9'(c); lenCode = 3'(code); burstType = typ[0];
    @(negedge clk);
    startIn = 1'b0;
  endtask

  // fixed-length burst, checks every beat, lastBeat and end
  task automatic fixedBurst(int c, int code, int typ, string tag);
    int len = 1 << code;
    issue(c, code, typ);
    for (int k = 0; k < len; k++) begin
      check(beatValid, {tag, " valid"}, beatValid, 1);
      check(colOut == 9'(expCol(c, len, typ, k)), {tag, " col"}, colOut, expCol(c, len, typ, k));
      check(lastBeat == (k == len - 1), "R9 lastBeat", lastBeat, k == len - 1);
      @(negedge clk);
    end
    check(!beatValid, "R1 beat count end", beatValid, 0);
  endtask

  task automatic tReset();
    check(!beatValid && !lastBeat && !errFlag, "R10 reset", {beatValid, lastBeat, errFlag}, 0);
  endtask

  task automatic tExamples();
    int seqL[8] = '{5, 6, 7, 0, 1, 2, 3, 4};
    int intL[8] = '{5, 4, 7, 6, 1, 0, 3, 2};
    issue(173, 3, 0);
    for (int k = 0; k < 8; k++) begin
      check(colOut == 9'(168 + seqL[k]), "R2 seq example", colOut, 168 + seqL[k]);
      @(negedge clk);
    end
    issue(173, 3, 1);
    for (int k = 0; k < 8; k++) begin
      check(colOut == 9'(168 + intL[k]), "R3 int example", colOut, 168 + intL[k]);
      @(negedge clk);
    end
  endtask

  task automatic tFixed();
    fixedBurst(301, 1, 0, "R2 len2");
    fixedBurst(302, 2, 0, "R2 len4");
    fixedBurst(511, 3, 0, "R2 len8");
    fixedBurst(86, 2, 1, "R3 len4");
    fixedBurst(407, 1, 1, "R3 len2");
    fixedBurst(3, 3, 1, "R3 len8");
    fixedBurst(77, 0, 1, "R5 len1 int");
    fixedBurst(78, 0, 0, "R5 len1 seq");
  endtask

  task automatic tFullPage();
    issue(509, 7, 0);
    for (int k = 0; k < 520; k++) begin
      check(beatValid && colOut == 9'((509 + k) % 512), "R4 full page col", colOut, (509 + k) % 512);
      check(!lastBeat, "R9 no last in full page", lastBeat, 0);
      if (k == 519) termIn = 1'b1;
      @(negedge clk);
    end
    termIn = 1'b0;
    check(!beatValid, "R6 terminate full page", beatValid, 0);
  endtask

  task automatic tTermFixed();
    issue(40, 3, 0);
    @(negedge clk);
    check(colOut == 9'd41, "R6 beat before term", colOut, 41);
    termIn = 1'b1;
    @(negedge clk);
    termIn = 1'b0;
    check(!beatValid, "R6 terminate fixed", beatValid, 0);
    @(negedge clk);
    check(!beatValid, "R6 stays idle", beatValid, 0);
  endtask

  task automatic tIllegal();
    for (int code = 4; code < 7; code++) begin
      issue(10, code, 0);
      check(errFlag && !beatValid, "R7 reserved code", {errFlag, beatValid}, 2);
      @(negedge clk);
      check(!errFlag && !beatValid, "R7 pulse one cycle", {errFlag, beatValid}, 0);
    end
    issue(10, 7, 1);
    check(errFlag && !beatValid, "R7 full page interleaved", {errFlag, beatValid}, 2);
    @(negedge clk);
    check(!errFlag, "R7 pulse ends", errFlag, 0);
  endtask

  task automatic tRestart();
    issue(0, 3, 0);
    @(negedge clk);
    @(negedge clk);
    check(colOut == 9'd2, "R8 old burst beat2", colOut, 2);
    startIn = 1'b1; startCol = 9'd100; lenCode = 3'd2; burstType = 1'b0;
    @(negedge clk);
    startIn = 1'b0;
    for (int k = 0; k < 4; k++) begin
      check(beatValid && colOut == 9'(100 + k), "R8 restart col", colOut, 100 + k);
      check(lastBeat == (k == 3), "R8 restart last", lastBeat, k == 3);
      @(negedge clk);
    end
    check(!beatValid, "R8 restart end", beatValid, 0);
  endtask

  initial begin
    #(200000 * 5);
    nErrors++;
    nChecks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    tReset();
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tExamples();
    tFixed();
    tFullPage();
    tTermFixed();
    tIllegal();
    tRestart();
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end
endmodule